// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block combines three reset requests into a single stretched system reset. The requests are an undervoltage flag that is already synchronous to the clock, an active-low manual reset pin, and a one-cycle timeout strobe from a watchdog. While any request is active, reset is asserted. Once the last request has gone away, reset is held for a fixed number of clock cycles before it releases.

The manual pin is asynchronous. It passes through a synchronizer and then a low-level qualifier, so that short negative glitches are rejected and only a sustained low requests reset. Reset is driven on an active-high output and an active-low output that are exact complements of each other. A status bit shows that reset is in progress, and a one-cycle marker flags the cycle in which reset releases. All times are parameters counted in clock cycles: `HOLD_CYC` for the hold, `MR_FILT_CYC` for manual qualification and `SYNC_STAGES` (default 2) for synchronizer depth.

Top module: `reset_pulse_gen`

## Requirements
- R1: After `rst_ni` is released with no request active, `sys_rst_o` stays high through the first `HOLD_CYC - 1` clock edges and goes low after edge number `HOLD_CYC`.
- R2: A high `uv_i` sampled at a clock edge makes `sys_rst_o` high after that edge, and it stays high while `uv_i` stays high.
- R3: After the last clock edge at which any request was sampled active, `sys_rst_o` stays high for exactly `HOLD_CYC` cycles. A new request during the hold restarts the full count.
- R4: A single one-cycle `wdt_i` strobe, with no other request, produces a `sys_rst_o` pulse exactly `HOLD_CYC` cycles long, starting after the edge that samples the strobe.
- R5: A low on `mr_ni` lasting fewer than `MR_FILT_CYC` consecutive clock samples has no effect on any output.
- R6: A low on `mr_ni` of at least `MR_FILT_CYC` consecutive samples asserts `sys_rst_o` after edge `MR_FILT_CYC + 2`, counting the first low-sampling edge as edge 0 (two synchronizer stages).
- R7: When `mr_ni` returns high with no other request, `sys_rst_o` goes low after edge `HOLD_CYC + 2`, counting the first high-sampling edge as edge 0.
- R8: `sys_rst_no` is always the complement of `sys_rst_o`, and `rst_busy_o` always equals `sys_rst_o`.
- R9: `rst_release_o` is high for exactly one cycle, the first cycle in which `sys_rst_o` is low after being high, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset (power-on) |
| uv_i | input | 1 | Synchronous undervoltage flag, active high |
| mr_ni | input | 1 | Asynchronous manual reset pin, active low |
| wdt_i | input | 1 | Watchdog timeout strobe, one cycle, active high |
| sys_rst_no | output | 1 | System reset, active low |
| sys_rst_o | output | 1 | System reset, active high |
| rst_busy_o | output | 1 | Status: reset in progress |
| rst_release_o | output | 1 | One-cycle marker of reset release |

## Verification
The hardest cases to reach are the exact qualification boundary of the manual pin and the timing of a hold restart. The boundary needs a low exactly one sample short of the threshold, and the restart needs a second request to land while the hold counter is still running. The stimulus drives `mr_ni` low for `MR_FILT_CYC - 1` and then `MR_FILT_CYC + 3` samples, with every intermediate cycle checked. It also fires a second watchdog strobe ten cycles into a running hold, and predicts the release cycle from the second strobe alone.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  typedef struct packed {
    logic uv;
    logic mr;
    logic wdt;
  } rpg_req_t;

  function automatic logic req_any(rpg_req_t r);
    return r.uv | r.mr | r.wdt;
  endfunction
endpackage

// File: rtl/rpg_mr_qual.sv
module rpg_mr_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mr_ni,
  output logic mr_act_o
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam logic [FW-1:0] LAST = FW'(FILT_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FW-1:0]          cnt_q;
  logic                   act_q;
  logic                   mr_lvl;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b1;
        else         sync_q[i] <= mr_ni;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b1;
        else         sync_q[i] <= sync_q[i-1];
    end
  end

  assign mr_lvl = sync_q[SYNC_STAGES-1];

  // any high sample drops qualification and reloads the filter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (mr_lvl) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      act_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mr_act_o = act_q;

  assert_qual_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(!mr_lvl));
  assert_drop_on_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_lvl |=> !act_q);
endmodule

// File: rtl/rpg_hold_timer.sv
module rpg_hold_timer #(
  parameter int HOLD_CYC = 1400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic busy_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  // power-on starts with a full hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= FULL;
    else if (req_i)         cnt_q <= FULL;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  assert_req_asserts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> busy_o);
  assert_no_early_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(!req_i));
  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
endmodule

// File: rtl/rpg_out_stage.sv
module rpg_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic rst_o,
  output logic rst_no,
  output logic busy_o,
  output logic rel_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= busy_i;

  assign rst_o  = busy_i;
  assign rst_no = ~busy_i;
  assign busy_o = busy_i;
  assign rel_o  = prev_q & ~busy_i;

  assert_rel_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_o |=> !rel_o);
  assert_rel_after_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> rel_o);
endmodule

// File: rtl/reset_pulse_gen.sv
module reset_pulse_gen #(
  parameter int HOLD_CYC    = 1400,
  parameter int MR_FILT_CYC = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_i,
  input  logic mr_ni,
  input  logic wdt_i,
  output logic sys_rst_no,
  output logic sys_rst_o,
  output logic rst_busy_o,
  output logic rst_release_o
);
  import rpg_pkg::*;

  rpg_req_t req;
  logic     mr_act;
  logic     busy;

  rpg_mr_qual #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(MR_FILT_CYC)) u_mr (
    .clk_i, .rst_ni, .mr_ni, .mr_act_o(mr_act)
  );

  assign req = '{uv: uv_i, mr: mr_act, wdt: wdt_i};

  rpg_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i, .rst_ni, .req_i(req_any(req)), .busy_o(busy)
  );

  rpg_out_stage u_out (
    .clk_i, .rst_ni, .busy_i(busy),
    .rst_o(sys_rst_o), .rst_no(sys_rst_no), .busy_o(rst_busy_o), .rel_o(rst_release_o)
  );

  assert_uv_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> sys_rst_o);
  assert_wdt_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_i |=> sys_rst_o);
  assert_complement_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_no != sys_rst_o);
endmodule

// File: tb/sim_reset_pulse_gen.sv
module sim_reset_pulse_gen;
  localparam int HOLD = 20;
  localparam int FILT = 5;

  typedef struct {
    int    cyc;
    bit    rst;
    bit    rel;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0, uv = 1'b0, mr_n = 1'b1, wdt = 1'b0;
  logic sys_rst_n, sys_rst, busy, rel;
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  reset_pulse_gen #(.HOLD_CYC(HOLD), .MR_FILT_CYC(FILT), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni, .uv_i(uv), .mr_ni(mr_n), .wdt_i(wdt),
    .sys_rst_no(sys_rst_n), .sys_rst_o(sys_rst), .rst_busy_o(busy), .rst_release_o(rel)
  );

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic push(int c, bit r, bit l, string tag);
    exp_t e;
    e.cyc = c; e.rst = r; e.rel = l; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.cyc < cyc) chk(0, e.tag, "missed sample cycle", cyc, e.cyc);
      else begin
        chk(sys_rst == e.rst, e.tag, "sys_rst_o", int'(sys_rst), int'(e.rst));
        chk(sys_rst_n == ~sys_rst, "R8", "sys_rst_no", int'(sys_rst_n), int'(~sys_rst));
        chk(busy == sys_rst, "R8", "rst_busy_o", int'(busy), int'(sys_rst));
        chk(rel == e.rel, {e.tag, "/R9"}, "rst_release_o", int'(rel), int'(e.rel));
      end
    end
  end

  task automatic wait_idle();
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int c;
    // R1 reset state and power-on hold
    push(0, 1, 0, "R1");
    repeat (3) @(negedge clk);
    push(1, 1, 0, "R1");
    push(HOLD - 1, 1, 0, "R1");
    push(HOLD, 0, 1, "R1");
    push(HOLD + 1, 0, 0, "R1");
    rst_ni = 1'b1;
    wait_idle();

    // R2 + R3: undervoltage for 10 samples
    @(negedge clk); c = cyc;
    push(c + 1, 1, 0, "R2");
    push(c + 10, 1, 0, "R2");
    push(c + 10 + HOLD - 1, 1, 0, "R3");
    push(c + 10 + HOLD, 0, 1, "R3");
    push(c + 11 + HOLD, 0, 0, "R3");
    uv = 1'b1;
    repeat (10) @(negedge clk);
    uv = 1'b0;
    wait_idle();

    // R4: single watchdog strobe
    @(negedge clk); c = cyc;
    push(c + 1, 1, 0, "R4");
    push(c + HOLD, 1, 0, "R4");
    push(c + HOLD + 1, 0, 1, "R4");
    push(c + HOLD + 2, 0, 0, "R4");
    wdt = 1'b1;
    @(negedge clk); wdt = 1'b0;
    wait_idle();

    // R3: second strobe during hold restarts it
    @(negedge clk); c = cyc;
    push(c + HOLD + 1, 1, 0, "R3");
    push(c + HOLD + 10, 1, 0, "R3");
    push(c + HOLD + 11, 0, 1, "R3");
    wdt = 1'b1;
    @(negedge clk); wdt = 1'b0;
    repeat (9) @(negedge clk);
    wdt = 1'b1;
    @(negedge clk); wdt = 1'b0;
    wait_idle();

    // R5: manual low one sample short of qualification
    @(negedge clk); c = cyc;
    for (int k = 1; k <= FILT + 6; k++) push(c + k, 0, 0, "R5");
    mr_n = 1'b0;
    repeat (FILT - 1) @(negedge clk);
    mr_n = 1'b1;
    wait_idle();

    // R6 + R7: qualified manual low of FILT+3 samples
    @(negedge clk); c = cyc;
    push(c + FILT + 2, 0, 0, "R6");
    push(c + FILT + 3, 1, 0, "R6");
    push(c + (FILT + 3) + HOLD + 2, 1, 0, "R7");
    push(c + (FILT + 3) + HOLD + 3, 0, 1, "R7");
    push(c + (FILT + 3) + HOLD + 4, 0, 0, "R7");
    mr_n = 1'b0;
    repeat (FILT + 3) @(negedge clk);
    mr_n = 1'b1;
    wait_idle();

    finish_run();
  end
endmodule